// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

This block sits between a host that issues word reads and writes and a 36-bit asynchronous DRAM module made of two 1M-deep banks. It turns each accepted request into the strobe sequence that such memory expects. The row half of the address goes out first and is latched when a row strobe falls. The column half follows and is latched when the column strobes fall. On a read, the word on the data pins is captured and handed back with a one-cycle valid pulse. Every timing limit is a parameter counted in clock cycles, rounded up from the nanosecond figure.

The data pins carry both directions, so every write is an early write. Write enable goes low one cycle before the column strobes fall, and the data lines carry the write word only on write columns. A request for the same bank and row can arrive while a row is open. Such a request is chained as a further column cycle with the row strobe held low, which gives a fast-page burst. The burst ends when the next request targets another row or bank, when no request is waiting, or when one more column would push the row strobe past its page-time budget. The row strobe then rises for precharge.

The controller is a seven-state machine:
- `ST_IDLE`: row strobes high, ready for a request.
- `ST_ROW`: row strobe low, row address on the bus.
- `ST_COL_SETUP`: column address and write enable set up.
- `ST_CAS`: column strobes low.
- `ST_CAS_PRE`: column strobes high again.
- `ST_RAS_HOLD`: row strobe kept low until its minimum width is met.
- `ST_PRECH`: row strobe high until precharge is complete.

The named transitions are:
- open (IDLE→ROW, on accept)
- select (ROW→COL_SETUP, after T_RCD)
- strobe (COL_SETUP→CAS)
- release (CAS→CAS_PRE, once the column, address and row access times are met)
- chain (CAS_PRE→COL_SETUP, same-page accept)
- hold (CAS_PRE→RAS_HOLD)
- close (CAS_PRE or RAS_HOLD→PRECH)
- rest (PRECH→IDLE)

Top module: `adram_seq`

## Requirements
- R1: After reset, and whenever idle with no request, all row strobes, all column strobes and write enable are high, `dq_oe` is low, `rd_valid` is low and `req_ready` is high.
- R2: Word address bit 20 selects the bank. Bank 0 drives `dram_ras_n[1:0]` low and bank 1 drives `dram_ras_n[3:2]` low, and the two banks are never active together. Bits 19:10 are on `dram_addr` when the row strobe falls, and bits 9:0 are on it when the column strobes fall.
- R3: The column strobes fall no sooner than T_RCD cycles after the row strobe falls. A column strobe is low only while the selected row strobe is low.
- R4: On a write, `dram_we_n` is low in the cycle before the column strobes fall and in the cycle they fall, and `dq_oe` is high. On a read, `dram_we_n` is high and `dq_oe` is low.
- R5: `dram_cas_n[k]` enables data bits 9k+8..9k. On a write it goes low only where lane enable bit k is 1. On a read all four go low.
- R6: Each read returns, in request order, the word most recently written to that address with its lane mask applied. It is flagged by `rd_valid` high for exactly one cycle.
- R7: A same-bank, same-row request that is pending when a column cycle ends is accepted without the row strobe rising.
- R8: A request to a different row or bank, or no pending request, makes the row strobe rise after the current column cycle.
- R9: The row strobe is never low for more than T_RASP cycles. A burst that would exceed this budget is closed and reopened.
- R10: The row strobe stays low for at least T_RAS cycles, and stays high for at least max(T_RP, T_RC−T_RAS) cycles between activations.
- R11: Column strobes stay low for at least T_CAS cycles and stay high for at least T_CP cycles between page columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address: bank, row, column |
| req_wdata | input | 36 | Write word |
| req_lanes | input | 4 | Write lane enables, 9 bits each |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 36 | Read word |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 4 | Row strobes, two per bank |
| dram_cas_n | output | 4 | Column strobes, one per lane |
| dram_we_n | output | 1 | Write enable, active low |
| dq_out | output | 36 | Data driven toward memory |
| dq_oe | output | 1 | Data driver enable |
| dq_in | input | 36 | Data returned from memory |

## Verification
The hardest case to reach is the page-budget close. It needs a long run of same-row requests presented back to back, so that the pending request is always present at the end of each column cycle and the row strobe is never released for any other reason. The bench shrinks T_RASP to 40 cycles and streams fourteen same-row reads with the valid line held high across them. It then counts row-strobe activations and checks that every word still returns in order. Row and bank changes are driven the same way, back to back, so that only the address comparison can end each burst.

// File: rtl/adram_pkg.sv
`timescale 1ns/1ps
package adram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL_SETUP,
        ST_CAS,
        ST_CAS_PRE,
        ST_RAS_HOLD,
        ST_PRECH
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adram_strobe_dec.sv
`timescale 1ns/1ps
module adram_strobe_dec #(
    parameter int LANES        = 4,
    parameter int RAS_PER_BANK = 2
) (
    input  logic                      ras_on,
    input  logic                      cas_on,
    input  logic                      bank,
    input  logic                      wr,
    input  logic [LANES-1:0]          lanes,
    output logic [2*RAS_PER_BANK-1:0] ras_n,
    output logic [LANES-1:0]          cas_n
);

    // row strobes: lower group belongs to bank 0, upper group to bank 1
    for (genvar g = 0; g < 2*RAS_PER_BANK; g++) begin : g_ras
        localparam bit SEL = (g >= RAS_PER_BANK);
        assign ras_n[g] = ~(ras_on && (bank == SEL));
    end

    // column strobes double as lane enables on writes
    for (genvar k = 0; k < LANES; k++) begin : g_cas
        assign cas_n[k] = ~(cas_on && (!wr || lanes[k]));
    end

endmodule

// File: rtl/adram_rd_capture.sv
`timescale 1ns/1ps
module adram_rd_capture #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cap_en;
            if (cap_en) rd_data <= dq_in;
        end
    end

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/adram_seq.sv
`timescale 1ns/1ps
module adram_seq
    import adram_pkg::*;
#(
    parameter int MUX_W        = 10,
    parameter int LANES        = 4,
    parameter int LANE_W       = 9,
    parameter int RAS_PER_BANK = 2,
    parameter int T_RCD        = 2,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 4,
    parameter int T_RC         = 11,
    parameter int T_CAS        = 2,
    parameter int T_CP         = 1,
    parameter int T_AA         = 3,
    parameter int T_RAC        = 6,
    parameter int T_RASP       = 20000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [2*MUX_W:0]          req_addr,
    input  logic [LANES*LANE_W-1:0]   req_wdata,
    input  logic [LANES-1:0]          req_lanes,
    output logic                      rd_valid,
    output logic [LANES*LANE_W-1:0]   rd_data,
    output logic [MUX_W-1:0]          dram_addr,
    output logic [2*RAS_PER_BANK-1:0] dram_ras_n,
    output logic [LANES-1:0]          dram_cas_n,
    output logic                      dram_we_n,
    output logic [LANES*LANE_W-1:0]   dq_out,
    output logic                      dq_oe,
    input  logic [LANES*LANE_W-1:0]   dq_in
);

    localparam int DW       = LANES * LANE_W;
    localparam int AW       = 2 * MUX_W + 1;
    localparam int CW       = 16;
    localparam int RP_EFF   = imax(T_RP, T_RC - T_RAS);
    localparam int CAS_N    = imax(T_CAS, T_AA - 1);
    localparam int COL_COST = 1 + imax(CAS_N, T_RAC) + T_CP;
    localparam int PAGE_LIM = T_RASP - 1 - COL_COST;

    localparam logic [CW-1:0] RCD_L  = CW'(T_RCD - 1);
    localparam logic [CW-1:0] CASX_L = CW'(CAS_N - 1);
    localparam logic [CW-1:0] RAC_L  = CW'(T_RAC - 1);
    localparam logic [CW-1:0] CP_L   = CW'(T_CP - 1);
    localparam logic [CW-1:0] RAS_L  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] RPX_L  = CW'(RP_EFF - 1);
    localparam logic [CW-1:0] PAGE_L = CW'(PAGE_LIM);

    seq_state_e        state, nxt;
    logic [CW-1:0]     st_cnt, ras_cnt;
    logic              cur_wr, cur_bank;
    logic [MUX_W-1:0]  cur_row, cur_col;
    logic [DW-1:0]     cur_wdata;
    logic [LANES-1:0]  cur_lanes;

    logic same_page, budget_ok, pre_last, cas_done, accept;
    logic ras_on, cas_on, we_on, cap_en;

    assign same_page = req_valid && (req_addr[AW-1] == cur_bank) &&
                       (req_addr[2*MUX_W-1:MUX_W] == cur_row);
    assign budget_ok = (ras_cnt <= PAGE_L);
    assign pre_last  = (st_cnt >= CP_L);
    assign cas_done  = (st_cnt >= CASX_L) && (cur_wr || ras_cnt >= RAC_L);
    assign req_ready = (state == ST_IDLE) ||
                       ((state == ST_CAS_PRE) && pre_last && same_page && budget_ok);
    assign accept    = req_valid && req_ready;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (accept) nxt = ST_ROW;
            ST_ROW:       if (st_cnt >= RCD_L) nxt = ST_COL_SETUP;
            ST_COL_SETUP: nxt = ST_CAS;
            ST_CAS:       if (cas_done) nxt = ST_CAS_PRE;
            ST_CAS_PRE: begin
                if (pre_last) begin
                    if (accept)                nxt = ST_COL_SETUP;
                    else if (ras_cnt >= RAS_L) nxt = ST_PRECH;
                    else                       nxt = ST_RAS_HOLD;
                end
            end
            ST_RAS_HOLD:  if (ras_cnt >= RAS_L) nxt = ST_PRECH;
            ST_PRECH:     if (st_cnt >= RPX_L) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state register, counters and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            st_cnt    <= '0;
            ras_cnt   <= '0;
            cur_wr    <= 1'b0;
            cur_bank  <= 1'b0;
            cur_row   <= '0;
            cur_col   <= '0;
            cur_wdata <= '0;
            cur_lanes <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)       st_cnt <= '0;
            else if (st_cnt != '1)  st_cnt <= st_cnt + 1'b1;
            if (!ras_on)            ras_cnt <= '0;
            else if (ras_cnt != '1) ras_cnt <= ras_cnt + 1'b1;
            if (accept) begin
                cur_wr    <= req_write;
                cur_bank  <= req_addr[AW-1];
                cur_row   <= req_addr[2*MUX_W-1:MUX_W];
                cur_col   <= req_addr[MUX_W-1:0];
                cur_wdata <= req_wdata;
                cur_lanes <= req_lanes;
            end
        end
    end

    // output decode
    always_comb begin
        ras_on    = 1'b0;
        cas_on    = 1'b0;
        we_on     = 1'b0;
        dq_oe     = 1'b0;
        cap_en    = 1'b0;
        dram_addr = cur_col;
        unique case (state)
            ST_IDLE:      dram_addr = req_addr[2*MUX_W-1:MUX_W];
            ST_ROW: begin
                ras_on    = 1'b1;
                dram_addr = cur_row;
            end
            ST_COL_SETUP: begin
                ras_on = 1'b1;
                we_on  = cur_wr;
                dq_oe  = cur_wr;
            end
            ST_CAS: begin
                ras_on = 1'b1;
                cas_on = 1'b1;
                we_on  = cur_wr;
                dq_oe  = cur_wr;
                cap_en = cas_done && !cur_wr;
            end
            ST_CAS_PRE: begin
                ras_on = 1'b1;
                dq_oe  = cur_wr;
            end
            ST_RAS_HOLD:  ras_on = 1'b1;
            ST_PRECH:     ras_on = 1'b0;
            default:      ras_on = 1'b0;
        endcase
    end

    assign dram_we_n = ~we_on;
    assign dq_out    = cur_wdata;

    adram_strobe_dec #(.LANES(LANES), .RAS_PER_BANK(RAS_PER_BANK)) strobe_i (
        .ras_on (ras_on),
        .cas_on (cas_on),
        .bank   (cur_bank),
        .wr     (cur_wr),
        .lanes  (cur_lanes),
        .ras_n  (dram_ras_n),
        .cas_n  (dram_cas_n)
    );

    adram_rd_capture #(.DW(DW)) capture_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .dq_in    (dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // assertion support: run lengths of the row strobe at the pins
    logic          ras_low_any, cas_low_any;
    logic [CW-1:0] lo_cnt, hi_cnt;
    assign ras_low_any = ~&dram_ras_n;
    assign cas_low_any = ~&dram_cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= CW'(RP_EFF);
        end else if (ras_low_any) begin
            hi_cnt <= '0;
            if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
        end else begin
            lo_cnt <= '0;
            if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R10
    ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_low_any) |-> hi_cnt >= CW'(RP_EFF));
    // R10
    ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_low_any) |-> lo_cnt >= CW'(T_RAS));
    // R9
    ras_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low_any |-> lo_cnt < CW'(T_RASP));
    // R3
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_low_any |-> ras_low_any);
    // R2
    bank_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~&dram_ras_n[2*RAS_PER_BANK-1:RAS_PER_BANK],
                  ~&dram_ras_n[RAS_PER_BANK-1:0]}));
    // R4
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_low_any) && cur_wr |-> !dram_we_n && $past(!dram_we_n));
    // R4
    dq_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dq_oe);

endmodule

// File: tb/adram_seq_tb.sv
`timescale 1ns/1ps
module adram_seq_tb_top;

    localparam int T_RCD  = 2;
    localparam int T_RAS  = 6;
    localparam int T_RP   = 4;
    localparam int T_RC   = 11;
    localparam int T_CAS  = 2;
    localparam int T_CP   = 1;
    localparam int T_RASP = 40;
    localparam int RP_MIN = (T_RP > T_RC - T_RAS) ? T_RP : T_RC - T_RAS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [35:0] req_wdata = '0;
    logic [3:0]  req_lanes = '0;
    logic        req_ready, rd_valid, dram_we_n, dq_oe;
    logic [35:0] rd_data, dq_out;
    logic [35:0] dq_in = '0;
    logic [9:0]  dram_addr;
    logic [3:0]  dram_ras_n, dram_cas_n;

    always #2.5 clk = ~clk;

    adram_seq #(.T_RASP(T_RASP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_lanes(req_lanes), .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int n_chk = 0, n_fail = 0, n_ras_fall = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [35:0] seed_word(input logic [20:0] a);
        return {a[17:0], ~a[17:0]};
    endfunction

    typedef struct { bit wr; logic [20:0] a; logic [35:0] d; logic [3:0] l; } rq_t;
    rq_t         pend_q[$];
    logic [35:0] exp_q[$];
    logic [35:0] shadow[int];
    logic [35:0] mem[int];

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] l);
        logic [35:0] r = old;
        for (int k = 0; k < 4; k++) if (l[k]) r[9*k +: 9] = nw[9*k +: 9];
        return r;
    endfunction

    task automatic issue(input bit wr, input logic [20:0] a, input logic [35:0] d, input logic [3:0] l);
        rq_t r;
        logic [35:0] cur;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = l;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        r.wr = wr; r.a = a; r.d = d; r.l = l;
        pend_q.push_back(r);
        cur = shadow.exists(int'(a)) ? shadow[int'(a)] : seed_word(a);
        if (wr) shadow[int'(a)] = merge(cur, d, l);
        else    exp_q.push_back(cur);
        @(posedge clk);
    endtask

    task automatic gap(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // behavioural memory and pin-level timing monitor, sampled mid-cycle
    bit          p_ras = 0, p_cas = 0, p_we = 0;
    int          lo_c = 0, hi_c = 100, cas_lo_c = 0, cas_hi_c = 100, since_ras = 0;
    logic        m_bank;
    logic [9:0]  m_row;

    always @(negedge clk) begin
        if (rst_n) begin
            bit ras_lo, cas_lo;
            ras_lo = ~&dram_ras_n;
            cas_lo = ~&dram_cas_n;
            if (cas_lo) chk(ras_lo, "R3 column strobe outside row", {63'b0, ras_lo}, 1);
            if (ras_lo && !p_ras) begin
                n_ras_fall++;
                chk(hi_c >= RP_MIN, "R10 precharge width", hi_c, RP_MIN);
                m_bank = ~&dram_ras_n[3:2];
                chk(dram_ras_n == (m_bank ? 4'b0011 : 4'b1100), "R2 bank strobe pair",
                    dram_ras_n, m_bank ? 4'b0011 : 4'b1100);
                m_row = dram_addr;
                since_ras = 0;
            end
            if (!ras_lo && p_ras) begin
                chk(lo_c >= T_RAS, "R10 row strobe width", lo_c, T_RAS);
                chk(lo_c <= T_RASP, "R9 page budget", lo_c, T_RASP);
            end
            if (cas_lo && !p_cas) begin
                rq_t r;
                logic [20:0] got;
                chk(pend_q.size() > 0, "R2 unexpected column cycle", pend_q.size(), 1);
                if (pend_q.size() > 0) begin
                    r = pend_q.pop_front();
                    got = {m_bank, m_row, dram_addr};
                    chk(got == r.a, "R2 row/column address", got, r.a);
                    chk(since_ras >= T_RCD, "R3 row-to-column delay", since_ras, T_RCD);
                    chk(cas_hi_c >= T_CP, "R11 column precharge", cas_hi_c, T_CP);
                    if (r.wr) begin
                        chk(!dram_we_n && p_we, "R4 early write enable", {p_we, dram_we_n}, 2'b10);
                        chk(dq_oe, "R4 data driven on write", dq_oe, 1);
                        chk(dram_cas_n == ~r.l, "R5 write lane strobes", dram_cas_n, ~r.l);
                        for (int k = 0; k < 4; k++) begin
                            if (!dram_cas_n[k]) begin
                                logic [35:0] w;
                                w = mem.exists(int'(got)) ? mem[int'(got)] : seed_word(got);
                                w[9*k +: 9] = dq_out[9*k +: 9];
                                mem[int'(got)] = w;
                            end
                        end
                    end else begin
                        chk(dram_we_n && !dq_oe, "R4 read direction", {dram_we_n, dq_oe}, 2'b10);
                        chk(dram_cas_n == 4'b0000, "R5 read lane strobes", dram_cas_n, 0);
                        dq_in = mem.exists(int'(got)) ? mem[int'(got)] : seed_word(got);
                    end
                end
            end
            if (!cas_lo && p_cas) chk(cas_lo_c >= T_CAS, "R11 column strobe width", cas_lo_c, T_CAS);
            if (rd_valid) begin
                chk(exp_q.size() > 0, "R6 unexpected read data", exp_q.size(), 1);
                if (exp_q.size() > 0) begin
                    logic [35:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R6 read data", rd_data, e);
                end
            end
            if (ras_lo) begin lo_c++; hi_c = 0; end else begin hi_c++; lo_c = 0; end
            if (cas_lo) begin cas_lo_c++; cas_hi_c = 0; end else begin cas_hi_c++; cas_lo_c = 0; end
            since_ras++;
            p_ras = ras_lo; p_cas = cas_lo; p_we = !dram_we_n;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dram_ras_n == 4'hF && dram_cas_n == 4'hF, "R1 strobes idle", {dram_ras_n, dram_cas_n}, 8'hFF);
        chk(dram_we_n && !dq_oe, "R1 write path idle", {dram_we_n, dq_oe}, 2'b10);
        chk(req_ready && !rd_valid, "R1 ready and no read data", {req_ready, rd_valid}, 2'b10);

        // R8: isolated accesses with no pending follower close the row
        base = n_ras_fall;
        issue(1, 21'h0_0C05, 36'h1_2345_6789, 4'hF);
        gap(15);
        issue(0, 21'h0_0C05, '0, 4'hF);
        gap(15);
        chk(n_ras_fall - base == 2, "R8 idle closes row", n_ras_fall - base, 2);

        // R7: same-row write burst then same-row read burst
        base = n_ras_fall;
        for (int i = 0; i < 4; i++) issue(1, 21'h1_5A00 + 21'(i), 36'hA_0000_0000 + 36'(i * 36'h111), 4'hF);
        gap(15);
        chk(n_ras_fall - base == 1, "R7 write burst one activation", n_ras_fall - base, 1);
        base = n_ras_fall;
        for (int i = 0; i < 4; i++) issue(0, 21'h1_5A00 + 21'(i), '0, 4'hF);
        gap(15);
        chk(n_ras_fall - base == 1, "R7 read burst one activation", n_ras_fall - base, 1);

        // R5: partial lane write merges with the stored word
        issue(1, 21'h0_3333, 36'hF_FFFF_FFFF, 4'hF);
        issue(1, 21'h0_3333, 36'h0_0000_0000, 4'b0101);
        issue(0, 21'h0_3333, '0, 4'hF);
        issue(1, 21'h0_3334, 36'h5_5555_5555, 4'b1000);
        issue(0, 21'h0_3334, '0, 4'hF);
        gap(15);

        // R8: back-to-back row changes in one bank
        base = n_ras_fall;
        issue(1, {1'b0, 10'd1, 10'd7}, 36'h1_1111_1111, 4'hF);
        issue(1, {1'b0, 10'd2, 10'd7}, 36'h2_2222_2222, 4'hF);
        issue(0, {1'b0, 10'd1, 10'd7}, '0, 4'hF);
        gap(15);
        chk(n_ras_fall - base == 3, "R8 row change closes burst", n_ras_fall - base, 3);

        // R2/R8: same row and column bits, alternating bank
        base = n_ras_fall;
        issue(1, {1'b1, 10'd9, 10'd3}, 36'h9_8765_4321, 4'hF);
        issue(0, {1'b0, 10'd9, 10'd3}, '0, 4'hF);
        issue(0, {1'b1, 10'd9, 10'd3}, '0, 4'hF);
        gap(15);
        chk(n_ras_fall - base == 3, "R8 bank change closes burst", n_ras_fall - base, 3);

        // R9: a long same-row stream must be split by the page budget
        base = n_ras_fall;
        for (int i = 0; i < 14; i++) issue(0, {1'b1, 10'h3FF, 10'(i * 5)}, '0, 4'hF);
        gap(20);
        chk(n_ras_fall - base >= 2, "R9 budget reopens row", n_ras_fall - base, 2);

        chk(exp_q.size() == 0 && pend_q.size() == 0, "R6 all reads returned",
            exp_q.size() + pend_q.size(), 0);
        finish_run();
    end

endmodule